// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches recent page translations so that a requester can turn a 32-bit virtual address into a physical address without a page-table access. The page size is 4 KB. The 64 entries are arranged as 16 sets of 4 ways. A lookup presents a virtual address and an access kind: read, write or execute. One cycle later the block returns exactly one of three results: a translated physical address, a permission fault, or a miss.

A miss is only reported. Whatever walks the page tables later installs the entry through the refill port. The refill lands in the set selected by the virtual page number, and a per-set recency order picks which way it replaces. A flush input empties the whole structure.

When a write hits an entry that is not yet marked dirty, the block raises a request to update the dirty bit. It never changes that bit itself. The refill agent must not install a page number that is already resident.

Top module: `tlb_sa`

## Requirements
- R1: Virtual address bits [15:12] select one of 16 sets and bits [31:16] are the stored tag, so four pages with the same set bits but different tags can be resident at once, and pages in different sets never evict each other.
- R2: A lookup that matches a valid entry with the needed permission gives, on the next cycle, `hit_o`=1 and `pa_o` = {stored physical page number, virtual address bits [11:0]}.
- R3: `resp_valid_o` is `lookup_valid_i` delayed by one cycle. When it is 1, exactly one of `hit_o`, `fault_o` and `miss_o` is 1. When it is 0, all four result outputs and `pa_o` are 0.
- R4: After reset every entry is invalid, all outputs are 0, and every lookup misses.
- R5: A lookup that matches no valid entry gives `miss_o`=1 and `pa_o`=0.
- R6: The access code on `lookup_acc_i` is 0 for read, 1 for write and 2 for execute; code 3 has no permission. In `refill_attr_i`, bit 0 grants read, bit 1 grants write, bit 2 grants execute and bit 3 is the dirty bit. A matching lookup whose permission bit is clear gives `fault_o`=1, `hit_o`=0 and `pa_o`=0.
- R7: A write that hits with write permission on an entry whose dirty bit is 0 gives `dirty_req_o`=1. The stored bit is left unchanged, so a repeated write raises the request again.
- R8: A refill writes the lowest-numbered invalid way of its set. If all four ways are valid, it writes the least recently used way.
- R9: The recency order of a set is updated by every matching lookup (hit or fault) and by every refill, and the touched way becomes the most recent. After reset the order from most to least recent is way 0, 1, 2, 3. A flush leaves the order unchanged.
- R10: A flush invalidates all 64 entries at one clock edge. A lookup in the same cycle still sees the old contents. A refill in the same cycle is dropped, and a matching lookup in that cycle does not update the recency order.
- R11: A lookup in the same cycle as a refill is answered from the contents before the refill. The refill's recency update takes the place of the lookup's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_va_i | input | 32 | Virtual address to translate |
| lookup_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| refill_valid_i | input | 1 | Install an entry |
| refill_vpn_i | input | 20 | Virtual page number of the new entry |
| refill_ppn_i | input | 20 | Physical page number of the new entry |
| refill_attr_i | input | 4 | {dirty, execute, write, read} |
| flush_i | input | 1 | Invalidate all entries |
| resp_valid_o | output | 1 | Result valid, one cycle after the lookup |
| hit_o | output | 1 | Translation valid |
| fault_o | output | 1 | Entry present but access not permitted |
| miss_o | output | 1 | No valid entry matched |
| dirty_req_o | output | 1 | Write hit on a clean entry; dirty bit must be set |
| pa_o | output | 32 | Physical address, 0 unless `hit_o` |

## Verification
The hardest state to reach from the ports is a full set whose recency order has been reshuffled by hits, faults and refills, so that the victim is neither the oldest install nor the way with the lowest number. The bench fills one set with four tags, touches them in a mixed order with reads, writes and execute accesses, then installs a fifth tag and probes all five to find out which one was evicted. It also overlaps refills and flushes with lookups in the same cycle. A long random phase then keeps a few sets over-subscribed with a small pool of tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef struct packed {
    logic dirty;
    logic exec;
    logic write;
    logic read;
  } attr_t;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     wr_en_i,
  input  logic [$clog2(SETS)-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]         wr_tag_i,
  input  logic [PPN_W-1:0]         wr_ppn_i,
  input  attr_t                    wr_attr_i,
  input  logic [$clog2(SETS)-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]         rd_tag_i,
  output logic                     match_o,
  output logic [PPN_W-1:0]         ppn_o,
  output attr_t                    attr_o,
  output logic                     wr_slot_valid_o
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  attr_t            attr_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      ppn_q[wr_idx_i]  <= wr_ppn_i;
      attr_q[wr_idx_i] <= wr_attr_i;
    end
  end

  assign match_o         = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign ppn_o           = ppn_q[rd_idx_i];
  assign attr_o          = attr_q[rd_idx_i];
  assign wr_slot_valid_o = valid_q[wr_idx_i];
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     touch_en_i,
  input  logic [$clog2(SETS)-1:0]  touch_idx_i,
  input  logic [$clog2(WAYS)-1:0]  touch_way_i,
  input  logic [$clog2(SETS)-1:0]  vic_idx_i,
  output logic [$clog2(WAYS)-1:0]  victim_o
);
  localparam int AGE_W = $clog2(WAYS);
  localparam int WAY_W = $clog2(WAYS);

  // age 0 = most recent, WAYS-1 = victim; ages of a set form a permutation
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_idx_i][w] <= '0;
        else if (age_q[touch_idx_i][w] < age_q[touch_idx_i][touch_way_i])
          age_q[touch_idx_i][w] <= age_q[touch_idx_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[vic_idx_i][w] == AGE_W'(WAYS - 1)) victim_o = WAY_W'(w);
  end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int WAYS      = 4,
  parameter int SETS      = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lookup_valid_i,
  input  logic [VA_W-1:0]           lookup_va_i,
  input  logic [1:0]                lookup_acc_i,
  input  logic                      refill_valid_i,
  input  logic [VA_W-PAGE_BITS-1:0] refill_vpn_i,
  input  logic [PA_W-PAGE_BITS-1:0] refill_ppn_i,
  input  logic [3:0]                refill_attr_i,
  input  logic                      flush_i,
  output logic                      resp_valid_o,
  output logic                      hit_o,
  output logic                      fault_o,
  output logic                      miss_o,
  output logic                      dirty_req_o,
  output logic [PA_W-1:0]           pa_o
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0] lk_idx, rf_idx;
  logic [TAG_W-1:0] lk_tag, rf_tag;
  assign lk_idx = lookup_va_i[PAGE_BITS +: IDX_W];
  assign lk_tag = lookup_va_i[VA_W-1 -: TAG_W];
  assign rf_idx = refill_vpn_i[IDX_W-1:0];
  assign rf_tag = refill_vpn_i[VPN_W-1 -: TAG_W];

  logic             rf_go;
  assign rf_go = refill_valid_i && !flush_i;

  logic [WAYS-1:0]  match, slot_vld, rf_wr;
  logic [PPN_W-1:0] way_ppn  [WAYS];
  attr_t            way_attr [WAYS];
  logic [WAY_W-1:0] rf_way, victim, hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rf_wr[w] = rf_go && (rf_way == WAY_W'(w));
    tlb_way #(.SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .flush_i        (flush_i),
      .wr_en_i        (rf_wr[w]),
      .wr_idx_i       (rf_idx),
      .wr_tag_i       (rf_tag),
      .wr_ppn_i       (refill_ppn_i),
      .wr_attr_i      (attr_t'(refill_attr_i)),
      .rd_idx_i       (lk_idx),
      .rd_tag_i       (lk_tag),
      .match_o        (match[w]),
      .ppn_o          (way_ppn[w]),
      .attr_o         (way_attr[w]),
      .wr_slot_valid_o(slot_vld[w])
    );
  end

  // invalid way first (lowest index wins), else recency victim
  always_comb begin
    rf_way = victim;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!slot_vld[w]) rf_way = WAY_W'(w);
  end

  // OR-mux: at most one way matches
  logic             hit_any;
  logic [PPN_W-1:0] sel_ppn;
  attr_t            sel_attr;
  always_comb begin
    hit_any  = |match;
    sel_ppn  = '0;
    sel_attr = '0;
    hit_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        sel_ppn  = sel_ppn | way_ppn[w];
        sel_attr = sel_attr | way_attr[w];
        hit_way  = hit_way | WAY_W'(w);
      end
    end
  end

  logic perm_ok;
  always_comb begin
    unique case (lookup_acc_i)
      ACC_READ:  perm_ok = sel_attr.read;
      ACC_WRITE: perm_ok = sel_attr.write;
      ACC_EXEC:  perm_ok = sel_attr.exec;
      default:   perm_ok = 1'b0;
    endcase
  end

  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;
  logic [WAY_W-1:0] touch_way;
  assign touch_en  = rf_go || (lookup_valid_i && hit_any && !flush_i);
  assign touch_idx = rf_go ? rf_idx : lk_idx;
  assign touch_way = rf_go ? rf_way : hit_way;

  tlb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_en_i (touch_en),
    .touch_idx_i(touch_idx),
    .touch_way_i(touch_way),
    .vic_idx_i  (rf_idx),
    .victim_o   (victim)
  );

  logic tr_ok;
  assign tr_ok = lookup_valid_i && hit_any && perm_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      miss_o       <= 1'b0;
      dirty_req_o  <= 1'b0;
      pa_o         <= '0;
    end else begin
      resp_valid_o <= lookup_valid_i;
      hit_o        <= tr_ok;
      fault_o      <= lookup_valid_i && hit_any && !perm_ok;
      miss_o       <= lookup_valid_i && !hit_any;
      dirty_req_o  <= tr_ok && (lookup_acc_i == ACC_WRITE) && !sel_attr.dirty;
      pa_o         <= tr_ok ? {sel_ppn, lookup_va_i[PAGE_BITS-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lookup_valid_i,
  input logic [VA_W-1:0] lookup_va_i,
  input logic            flush_i,
  input logic            resp_valid_o,
  input logic            hit_o,
  input logic            fault_o,
  input logic            miss_o,
  input logic            dirty_req_o,
  input logic [PA_W-1:0] pa_o
);
  AST_RESP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> resp_valid_o); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $countones({hit_o, fault_o, miss_o}) == 1); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(hit_o || fault_o || miss_o || dirty_req_o) && pa_o == '0); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (!hit_o || pa_o[PAGE_BITS-1:0] == $past(lookup_va_i[PAGE_BITS-1:0]))); // R2
  AST_MISS_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> pa_o == '0 && !dirty_req_o); // R5
  AST_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pa_o == '0 && !dirty_req_o); // R6
  AST_DIRTY_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_req_o |-> hit_o); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i ##1 lookup_valid_i) |=> miss_o); // R10
endmodule

bind tlb_sa tlb_sa_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .lookup_va_i   (lookup_va_i),
  .flush_i       (flush_i),
  .resp_valid_o  (resp_valid_o),
  .hit_o         (hit_o),
  .fault_o       (fault_o),
  .miss_o        (miss_o),
  .dirty_req_o   (dirty_req_o),
  .pa_o          (pa_o)
);

// File: tb/tb_tlb_sa.sv
module tb_tlb_sa;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lookup_valid;
  logic [31:0] lookup_va;
  logic [1:0]  lookup_acc;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [19:0] refill_ppn;
  logic [3:0]  refill_attr;
  logic        flush;
  logic        resp_valid, hit, fault, miss, dirty_req;
  logic [31:0] pa;

  always #2 clk = ~clk;

  tlb_sa dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lookup_valid), .lookup_va_i(lookup_va), .lookup_acc_i(lookup_acc),
    .refill_valid_i(refill_valid), .refill_vpn_i(refill_vpn), .refill_ppn_i(refill_ppn),
    .refill_attr_i(refill_attr), .flush_i(flush),
    .resp_valid_o(resp_valid), .hit_o(hit), .fault_o(fault), .miss_o(miss),
    .dirty_req_o(dirty_req), .pa_o(pa)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit        m_vld  [16][4];
  int        m_tag  [16][4];
  int        m_ppn  [16][4];
  bit [3:0]  m_attr [16][4];
  int        m_rec  [16][$]; // front = most recent

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void touch(int s, int w);
    for (int i = 0; i < m_rec[s].size(); i++)
      if (m_rec[s][i] == w) begin m_rec[s].delete(i); break; end
    m_rec[s].push_front(w);
  endfunction

  function automatic bit resident(bit [19:0] vpn);
    int s = int'(vpn[3:0]);
    for (int w = 0; w < 4; w++)
      if (m_vld[s][w] && m_tag[s][w] == int'(vpn[19:4])) return 1;
    return 0;
  endfunction

  function automatic bit [31:0] va_of(int tg, int idx, int off);
    return {tg[15:0], idx[3:0], off[11:0]};
  endfunction

  task automatic step(bit lv, bit [31:0] va, bit [1:0] acc, bit rf, bit [19:0] rvpn,
                      bit [19:0] rppn, bit [3:0] rattr, bit fl, string tag);
    int  s, mw, rs, rw;
    bit  ok, e_hit, e_fault, e_miss, e_dirty;
    bit [31:0] e_pa;
    lookup_valid = lv; lookup_va = va; lookup_acc = acc;
    refill_valid = rf; refill_vpn = rvpn; refill_ppn = rppn; refill_attr = rattr;
    flush = fl;
    s  = int'(va[15:12]);
    mw = -1;
    for (int w = 0; w < 4; w++)
      if (m_vld[s][w] && m_tag[s][w] == int'(va[31:16])) mw = w;
    ok      = (mw >= 0) && (acc != 2'd3) && m_attr[s][mw][acc];
    e_hit   = lv && ok;
    e_fault = lv && mw >= 0 && !ok;
    e_miss  = lv && mw < 0;
    e_dirty = e_hit && acc == 2'd1 && !m_attr[s][mw][3];
    e_pa    = e_hit ? {m_ppn[s][mw][19:0], va[11:0]} : 32'h0;
    if (fl) begin
      for (int i = 0; i < 16; i++) for (int w = 0; w < 4; w++) m_vld[i][w] = 0;
    end else if (rf) begin
      rs = int'(rvpn[3:0]);
      rw = m_rec[rs][$];
      for (int w = 3; w >= 0; w--) if (!m_vld[rs][w]) rw = w;
      m_vld[rs][rw] = 1; m_tag[rs][rw] = int'(rvpn[19:4]);
      m_ppn[rs][rw] = int'(rppn); m_attr[rs][rw] = rattr;
      touch(rs, rw);
    end else if (lv && mw >= 0) begin
      touch(s, mw);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R3", "resp_valid", resp_valid, lv);
    chk(tag, "hit", hit, e_hit);
    chk(e_fault ? "R6" : tag, "fault", fault, e_fault);
    chk(e_miss ? "R5" : tag, "miss", miss, e_miss);
    chk(e_dirty ? "R7" : tag, "dirty_req", dirty_req, e_dirty);
    chk(e_hit ? "R2" : tag, "pa", pa, e_pa);
  endtask

  task automatic look(bit [31:0] va, bit [1:0] acc, string tag);
    step(1, va, acc, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic fill(int tg, int idx, int ppn, bit [3:0] attr, string tag);
    step(0, '0, '0, 1, {tg[15:0], idx[3:0]}, ppn[19:0], attr, 0, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
      for (int w = 0; w < 4; w++) m_rec[s].push_back(w);
    end
    rst_n = 0; lookup_valid = 0; lookup_va = '0; lookup_acc = '0;
    refill_valid = 0; refill_vpn = '0; refill_ppn = '0; refill_attr = '0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R4: outputs quiet in reset
    chk("R4", "reset resp_valid", resp_valid, 0);
    chk("R4", "reset hit", hit, 0);
    chk("R4", "reset pa", pa, 0);
    rst_n = 1;
    @(negedge clk);

    look(va_of(1, 3, 12'h0), 2'd0, "R4");
    look(va_of(10, 3, 12'h0), 2'd0, "R4");

    // R1 R8: fill set 3 into invalid ways 0..3
    fill(10, 3, 20'h100, 4'b0001, "R8");
    fill(11, 3, 20'h101, 4'b0011, "R8");
    fill(12, 3, 20'h102, 4'b1011, "R8");
    fill(13, 3, 20'h103, 4'b0100, "R8");
    // R1: same tag, other set, independent
    fill(10, 5, 20'h2aa, 4'b0111, "R1");
    look(va_of(10, 5, 12'h5a5), 2'd2, "R1");

    look(va_of(10, 3, 12'hfff), 2'd0, "R2");
    look(va_of(10, 3, 12'h010), 2'd1, "R6");
    look(va_of(10, 3, 12'h010), 2'd2, "R6");
    look(va_of(11, 3, 12'h020), 2'd1, "R7");
    look(va_of(11, 3, 12'h024), 2'd1, "R7");
    look(va_of(12, 3, 12'h030), 2'd1, "R7");
    look(va_of(13, 3, 12'h040), 2'd2, "R2");
    look(va_of(13, 3, 12'h040), 2'd0, "R6");
    look(va_of(11, 3, 12'h044), 2'd3, "R6");

    // R9: reorder recency, then evict; probe all five
    look(va_of(12, 3, 0), 2'd0, "R9");
    look(va_of(10, 3, 0), 2'd0, "R9");
    look(va_of(13, 3, 0), 2'd1, "R9");
    fill(14, 3, 20'h104, 4'b0111, "R8");
    for (int t = 10; t <= 14; t++) look(va_of(t, 3, 12'h1), 2'd0, "R8");
    fill(15, 3, 20'h105, 4'b0001, "R9");
    for (int t = 10; t <= 15; t++) look(va_of(t, 3, 12'h2), 2'd0, "R9");

    // R11: lookup alongside refill in the same set
    step(1, va_of(12, 3, 12'h3), 2'd0, 1, {16'd16, 4'd3}, 20'h106, 4'b0001, 0, "R11");
    for (int t = 10; t <= 16; t++) look(va_of(t, 3, 12'h4), 2'd0, "R11");

    // R10: flush with lookup, refill dropped
    step(1, va_of(10, 5, 12'h7), 2'd0, 1, {16'd20, 4'd6}, 20'h300, 4'b0001, 1, "R10");
    look(va_of(10, 5, 12'h7), 2'd0, "R10");
    look(va_of(20, 6, 12'h7), 2'd0, "R10");
    fill(21, 3, 20'h301, 4'b0001, "R10");
    look(va_of(21, 3, 12'h8), 2'd0, "R10");

    // random phase: small tag pool over-subscribes sets
    for (int n = 0; n < 3000; n++) begin
      bit        lv  = ($urandom % 4) != 0;
      bit [31:0] va  = va_of(int'($urandom % 6), int'($urandom % 3), int'($urandom % 4096));
      bit [1:0]  acc = 2'($urandom % 4);
      bit        rf  = ($urandom % 5) == 0;
      bit [19:0] vpn = {16'($urandom % 6), 4'($urandom % 3)};
      bit        fl  = ($urandom % 60) == 0;
      if (resident(vpn)) rf = 0;
      step(lv, va, acc, rf, vpn, 20'($urandom), 4'($urandom), fl, "R9");
    end

    step(0, '0, '0, 0, '0, '0, '0, 0, "R3");
    done = 1;
    summary();
    $finish;
  end
endmodule